// File: doc/BRIEF.md
# Register-File Bus Slave with Hardware Load Port

This block is a bus slave on an AHB-Lite bus. It holds a small register file of two 32-bit entries. Each entry is made of two 16-bit fields, so the file has four fields in all. Software reads and writes the fields over the bus as words, halfwords or bytes. Surrounding hardware can also load any field directly through a data input and an enable that belong to that field alone.

Every valid access completes with no wait states. An access to any byte address outside the eight mapped bytes is refused with the two-cycle error response that the protocol defines. Field storage is a set of plain registers, so the state can be read back over the bus in the data phase that follows the address phase.

Top module: `ahbreg_slave`

## Requirements
- R1: While the synchronous active-high `rst` is high at a clock edge, all four fields are cleared to zero, `hreadyout` goes to 1 and `hresp` goes to 0.
- R2: A word (`hsize`=2) written at byte address 0 or 4 reads back unchanged as a word at the same address.
- R3: Halfword accesses (`hsize`=1) at byte offsets 0, 2, 4 and 6 reach one field each. A read returns the whole 32-bit entry on `hrdata`: the field at offset 0 or 4 on bits 15:0 and the field at offset 2 or 6 on bits 31:16. A halfword write changes only the addressed field.
- R4: A byte write (`hsize`=0) changes only the byte lane that `haddr[1:0]` selects, with lane n on `hwdata[8n+7:8n]`. Every other byte keeps its value.
- R5: When a field's bit of `hw_we` is 1 at a rising edge, that field loads its 16-bit slice of `hw_data`. Field k uses bits 16k+15:16k, where fields 0 to 3 sit at byte offsets 0, 2, 4 and 6.
- R6: While a field's `hw_we` bit is 0, its `hw_data` slice is ignored and the field keeps its value.
- R7: When a bus write and a hardware load reach the same field at the same edge, the hardware value is stored.
- R8: An accepted transfer to address 8 or above gives `hresp`=1 with `hreadyout`=0 in the first data-phase cycle, then `hresp`=1 with `hreadyout`=1 in the second cycle, for reads and writes alike.
- R9: A refused write leaves every field unchanged.
- R10: An accepted transfer to a mapped address completes with `hreadyout`=1 and `hresp`=0 in its first data-phase cycle.
- R11: A transfer is accepted only when `hsel`=1, `htrans` is NONSEQ (2'b10) or SEQ (2'b11), and `hready`=1. Otherwise there is no write, and the response stays OKAY with `hreadyout`=1.
- R12: A write followed at once by a read of the same address, in pipelined phases, returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Byte address (address phase) |
| htrans | input | 2 | Transfer type |
| hsize | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hwrite | input | 1 | 1 for write |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus-wide ready, the previous transfer has finished |
| hrdata | output | 32 | Read data: the selected entry |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 1 | 1 for error response |
| hw_we | input | 4 | Per-field hardware load enable |
| hw_data | input | 64 | Per-field hardware load data, 16 bits per field |

## Verification
A reference copy of the four fields is kept in the bench. Seeded random words, halfwords and bytes at aligned mapped offsets are mixed with random unmapped addresses and random hardware loads. This separates lane-selection faults from entry-selection faults, and it separates faults in the error sequence from faults that corrupt storage on a refused access.

Directed cases cover the following:
- reset
- a bus write and a hardware load to the same field at the same edge
- a held-low enable while `hw_data` changes
- transfers with `hsel` low, IDLE or BUSY
- a write followed at once by a read of the same address

These isolate priority, gating, qualification and pipeline forwarding.

// File: rtl/ahbreg_pkg.sv
package ahbreg_pkg;

  typedef enum logic [1:0] {
    RSP_OKAY     = 2'd0,
    RSP_ERR_WAIT = 2'd1,
    RSP_ERR_DONE = 2'd2
  } rsp_state_e;

  typedef struct packed {
    logic       act;
    logic       wr;
    logic [2:0] size;
  } dphase_t;

endpackage

// File: rtl/ahbreg_capture.sv
module ahbreg_capture #(
  parameter int ADDR_W    = 32,
  parameter int MAP_BYTES = 8,
  parameter int OFF_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hsel,
  input  logic [1:0]             htrans,
  input  logic                   hready,
  input  logic [ADDR_W-1:0]      haddr,
  input  logic                   hwrite,
  input  logic [2:0]             hsize,
  output ahbreg_pkg::dphase_t    dp,
  output logic [OFF_W-1:0]       dp_off,
  output logic                   bad_req
);
  logic accept;
  logic in_map;

  assign accept  = hsel && htrans[1] && hready;
  assign in_map  = haddr < ADDR_W'(MAP_BYTES);
  assign bad_req = accept && !in_map;

  always_ff @(posedge clk) begin
    if (rst) begin
      dp     <= '0;
      dp_off <= '0;
    end else if (hready) begin
      dp.act  <= accept && in_map;
      dp.wr   <= hwrite;
      dp.size <= hsize;
      dp_off  <= haddr[OFF_W-1:0];
    end
  end
endmodule

// File: rtl/ahbreg_resp.sv
module ahbreg_resp (
  input  logic clk,
  input  logic rst,
  input  logic bad_req,
  output logic hreadyout,
  output logic hresp
);
  import ahbreg_pkg::*;

  rsp_state_e state, nxt;

  always_comb begin
    case (state)
      RSP_OKAY:     nxt = bad_req ? RSP_ERR_WAIT : RSP_OKAY;
      RSP_ERR_WAIT: nxt = RSP_ERR_DONE;
      RSP_ERR_DONE: nxt = bad_req ? RSP_ERR_WAIT : RSP_OKAY;
      default:      nxt = RSP_OKAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RSP_OKAY;
      hreadyout <= 1'b1;
      hresp     <= 1'b0;
    end else begin
      state     <= nxt;
      hreadyout <= (nxt != RSP_ERR_WAIT);
      hresp     <= (nxt != RSP_OKAY);
    end
  end
endmodule

// File: rtl/ahbreg_field.sv
module ahbreg_field #(
  parameter int FIELD_W = 16,
  localparam int FLANES = FIELD_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hw_we,
  input  logic [FIELD_W-1:0] hw_d,
  input  logic [FLANES-1:0]  bus_be,
  input  logic [FIELD_W-1:0] bus_d,
  output logic [FIELD_W-1:0] q
);
  for (genvar l = 0; l < FLANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)            q[l*8 +: 8] <= '0;
      else if (hw_we)     q[l*8 +: 8] <= hw_d[l*8 +: 8];
      else if (bus_be[l]) q[l*8 +: 8] <= bus_d[l*8 +: 8];
    end
  end
endmodule

// File: rtl/ahbreg_slave.sv
module ahbreg_slave #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 16,
  parameter int N_ENTRY = 2,
  localparam int FPW        = DATA_W / FIELD_W,
  localparam int NUM_FIELDS = N_ENTRY * FPW
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          hsel,
  input  logic [ADDR_W-1:0]             haddr,
  input  logic [1:0]                    htrans,
  input  logic [2:0]                    hsize,
  input  logic                          hwrite,
  input  logic [DATA_W-1:0]             hwdata,
  input  logic                          hready,
  output logic [DATA_W-1:0]             hrdata,
  output logic                          hreadyout,
  output logic                          hresp,
  input  logic [NUM_FIELDS-1:0]         hw_we,
  input  logic [NUM_FIELDS*FIELD_W-1:0] hw_data
);
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_AW   = $clog2(LANES);
  localparam int MAP_BYTES = N_ENTRY * LANES;
  localparam int OFF_W     = $clog2(MAP_BYTES);
  localparam int ENT_W     = OFF_W - LANE_AW;
  localparam int FLANES    = FIELD_W / 8;

  ahbreg_pkg::dphase_t dp;
  logic [OFF_W-1:0]    dp_off;
  logic                bad_req;
  logic                wr_en;
  logic [ENT_W-1:0]    ent_sel;
  logic [LANES-1:0]    be;
  logic [NUM_FIELDS*FIELD_W-1:0] fld_flat;

  ahbreg_capture #(.ADDR_W(ADDR_W), .MAP_BYTES(MAP_BYTES), .OFF_W(OFF_W)) u_cap (
    .clk(clk), .rst(rst), .hsel(hsel), .htrans(htrans), .hready(hready),
    .haddr(haddr), .hwrite(hwrite), .hsize(hsize),
    .dp(dp), .dp_off(dp_off), .bad_req(bad_req)
  );

  ahbreg_resp u_rsp (
    .clk(clk), .rst(rst), .bad_req(bad_req),
    .hreadyout(hreadyout), .hresp(hresp)
  );

  assign wr_en   = dp.act && dp.wr && hready;
  assign ent_sel = dp_off[OFF_W-1:LANE_AW];

  always_comb begin
    int span;
    int base;
    span = (int'(dp.size) >= LANE_AW) ? LANES : (1 << dp.size);
    base = int'(dp_off[LANE_AW-1:0]) & ~(span - 1);
    for (int b = 0; b < LANES; b++) be[b] = (b >= base) && (b < base + span);
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam int POS = f % FPW;
    logic [FLANES-1:0] f_be;
    assign f_be = be[POS*FLANES +: FLANES] &
                  {FLANES{wr_en && (ent_sel == ENT_W'(f / FPW))}};
    ahbreg_field #(.FIELD_W(FIELD_W)) u_fld (
      .clk(clk), .rst(rst),
      .hw_we(hw_we[f]), .hw_d(hw_data[f*FIELD_W +: FIELD_W]),
      .bus_be(f_be), .bus_d(hwdata[POS*FIELD_W +: FIELD_W]),
      .q(fld_flat[f*FIELD_W +: FIELD_W])
    );
  end

  assign hrdata = fld_flat[ent_sel*DATA_W +: DATA_W];
endmodule

// File: rtl/ahbreg_chk.sv
module ahbreg_chk #(
  parameter int ADDR_W     = 32,
  parameter int FIELD_W    = 16,
  parameter int NUM_FIELDS = 4,
  parameter int MAP_BYTES  = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          hsel,
  input logic [ADDR_W-1:0]             haddr,
  input logic [1:0]                    htrans,
  input logic                          hready,
  input logic                          hreadyout,
  input logic                          hresp,
  input logic [NUM_FIELDS-1:0]         hw_we,
  input logic [NUM_FIELDS*FIELD_W-1:0] hw_data,
  input logic [NUM_FIELDS*FIELD_W-1:0] fld_flat,
  input logic                          wr_en
);
  logic acc;
  assign acc = hsel && htrans[1] && hready;

  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (rst)
    acc && (haddr >= ADDR_W'(MAP_BYTES)) |=> hresp && !hreadyout); // R8
  AST_ERR_SECOND: assert property (@(posedge clk) disable iff (rst)
    hresp && !hreadyout |=> hresp && hreadyout); // R8
  AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (rst)
    acc && (haddr < ADDR_W'(MAP_BYTES)) |=> hreadyout && !hresp); // R10
  AST_IDLE_OKAY: assert property (@(posedge clk) disable iff (rst)
    !acc && hreadyout && !hresp |=> hreadyout && !hresp); // R11

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_f
    AST_HW_LOAD: assert property (@(posedge clk) disable iff (rst)
      hw_we[f] |=> fld_flat[f*FIELD_W +: FIELD_W] == $past(hw_data[f*FIELD_W +: FIELD_W])); // R5
    AST_HW_HOLD: assert property (@(posedge clk) disable iff (rst)
      !hw_we[f] && !wr_en |=> $stable(fld_flat[f*FIELD_W +: FIELD_W])); // R6
  end
endmodule

bind ahbreg_slave ahbreg_chk #(
  .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .MAP_BYTES(MAP_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
  .hready(hready), .hreadyout(hreadyout), .hresp(hresp), .hw_we(hw_we),
  .hw_data(hw_data), .fld_flat(fld_flat), .wr_en(wr_en)
);

// File: tb/sim_ahbreg_slave.sv
module sim_ahbreg_slave;
  logic        clk = 1'b0;
  logic        rst;
  logic        hsel;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic [2:0]  hsize;
  logic        hwrite;
  logic [31:0] hwdata;
  logic        hready;
  logic [31:0] hrdata;
  logic        hreadyout;
  logic        hresp;
  logic [3:0]  hw_we;
  logic [63:0] hw_data;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] exp_f [4];

  always #10 clk = ~clk;
  assign hready = hreadyout;

  ahbreg_slave u0 (
    .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hsize(hsize), .hwrite(hwrite), .hwdata(hwdata), .hready(hready),
    .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp),
    .hw_we(hw_we), .hw_data(hw_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    int e = int'(a[2]);
    return {exp_f[e*2+1], exp_f[e*2]};
  endfunction

  function automatic void model_wr(input logic [31:0] a, input logic [2:0] sz,
                                   input logic [31:0] d);
    int e = int'(a[2]);
    for (int b = 0; b < 4; b++) begin
      logic hit;
      case (sz)
        3'd0:    hit = (b == int'(a[1:0]));
        3'd1:    hit = ((b / 2) == int'(a[1]));
        default: hit = 1'b1;
      endcase
      if (hit) exp_f[e*2 + b/2][(b%2)*8 +: 8] = d[b*8 +: 8];
    end
  endfunction

  task automatic xfer(input logic wr, input logic [31:0] a, input logic [2:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output logic [1:0] ph1, output logic [1:0] ph2);
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = wr; hsize = sz;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwdata = wd;
    ph1 = {hreadyout, hresp};
    rd  = hrdata;
    @(negedge clk);
    ph2 = {hreadyout, hresp};
  endtask

  task automatic hw_load(input logic [3:0] m, input logic [63:0] d);
    @(negedge clk);
    hw_we = m; hw_data = d;
    @(negedge clk);
    hw_we = '0; hw_data = {$urandom, $urandom};
    for (int f = 0; f < 4; f++) if (m[f]) exp_f[f] = d[f*16 +: 16];
  endtask

  task automatic read_all(input string req);
    logic [31:0] rd;
    logic [1:0] p1, p2;
    xfer(1'b0, 32'd0, 3'd2, 32'd0, rd, p1, p2);
    chk(req, rd, exp_word(32'd0));
    xfer(1'b0, 32'd4, 3'd2, 32'd0, rd, p1, p2);
    chk(req, rd, exp_word(32'd4));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [1:0]  p1, p2;
    void'($urandom(32'd20211011));
    rst = 1'b1; hsel = 0; haddr = 0; htrans = 0; hsize = 0; hwrite = 0;
    hwdata = 0; hw_we = 0; hw_data = 0;
    for (int f = 0; f < 4; f++) exp_f[f] = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready/resp", {30'd0, hreadyout, hresp}, 32'd2);
    rst = 1'b0;
    read_all("R1 fields zero");

    xfer(1'b1, 32'd0, 3'd2, 32'hDEADBEEF, rd, p1, p2); model_wr(0, 2, 32'hDEADBEEF);
    chk("R10 word write okay", {30'd0, p1}, 32'd2);
    xfer(1'b1, 32'd4, 3'd2, 32'h12345678, rd, p1, p2); model_wr(4, 2, 32'h12345678);
    read_all("R2 word readback");

    xfer(1'b1, 32'd2, 3'd1, 32'hA55A0000, rd, p1, p2); model_wr(2, 1, 32'hA55A0000);
    xfer(1'b0, 32'd0, 3'd2, 0, rd, p1, p2);
    chk("R3 halfword at 2", rd, 32'hA55ABEEF);
    xfer(1'b1, 32'd4, 3'd1, 32'hFFFF0C0C, rd, p1, p2); model_wr(4, 1, 32'hFFFF0C0C);
    xfer(1'b0, 32'd6, 3'd1, 0, rd, p1, p2);
    chk("R3 halfword at 4", rd, 32'h12340C0C);

    xfer(1'b1, 32'd5, 3'd0, 32'h00009C00, rd, p1, p2); model_wr(5, 0, 32'h00009C00);
    xfer(1'b0, 32'd4, 3'd2, 0, rd, p1, p2);
    chk("R4 byte lane 1", rd, 32'h12349C0C);

    hw_load(4'b1000, 64'h0F0F_0000_0000_0000);
    read_all("R5 hw load field 3");

    for (int i = 0; i < 5; i++) begin
      @(negedge clk); hw_we = '0; hw_data = {$urandom, $urandom};
    end
    read_all("R6 hw input ignored");

    @(negedge clk);
    hsel = 1; htrans = 2'b10; haddr = 0; hwrite = 1; hsize = 2;
    @(negedge clk);
    hsel = 0; htrans = 0; hwdata = 32'h11112222; hw_we = 4'b0001; hw_data = 64'h7E7E;
    @(negedge clk);
    hw_we = 0;
    exp_f[0] = 16'h7E7E; exp_f[1] = 16'h1111;
    read_all("R7 hw beats bus");

    xfer(1'b1, 32'd8, 3'd2, 32'hCAFEF00D, rd, p1, p2);
    chk("R8 write err first", {30'd0, p1}, 32'd1);
    chk("R8 write err second", {30'd0, p2}, 32'd3);
    xfer(1'b0, 32'h100, 3'd1, 0, rd, p1, p2);
    chk("R8 read err first", {30'd0, p1}, 32'd1);
    chk("R8 read err second", {30'd0, p2}, 32'd3);
    read_all("R9 no write on error");

    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      hsel = (c != 0); htrans = (c == 0) ? 2'b10 : ((c == 1) ? 2'b00 : 2'b01);
      haddr = 0; hwrite = 1; hsize = 2;
      @(negedge clk);
      hsel = 0; htrans = 0; hwdata = $urandom;
      chk("R11 okay response", {30'd0, hreadyout, hresp}, 32'd2);
      @(negedge clk);
    end
    read_all("R11 not written");

    @(negedge clk);
    hsel = 1; htrans = 2'b10; haddr = 4; hwrite = 1; hsize = 2;
    @(negedge clk);
    hwrite = 0; hwdata = 32'h600DD00D;
    @(negedge clk);
    hsel = 0; htrans = 0;
    chk("R12 back-to-back", hrdata, 32'h600DD00D);
    model_wr(4, 2, 32'h600DD00D);
    @(negedge clk);

    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom % 8);
      if (r == 0) begin
        xfer($urandom % 2 == 0, 32'd8 + ($urandom % 1000), 3'd2, $urandom, rd, p1, p2);
        chk("R8 random err", {30'd0, p1, p2}, 32'h7);
      end else if (r == 1) begin
        hw_load(4'($urandom), {$urandom, $urandom});
      end else begin
        logic [2:0]  sz = 3'($urandom % 3);
        logic [31:0] a  = 32'($urandom % 8) & ~((32'd1 << sz) - 1);
        logic        wr = 1'($urandom);
        logic [31:0] d  = $urandom;
        xfer(wr, a, sz, d, rd, p1, p2);
        chk("R10 random okay", {30'd0, p1}, 32'd2);
        if (wr) model_wr(a, sz, d);
        else chk("R2/R3/R4 random read", rd, exp_word(a));
      end
    end
    read_all("R2 final state");
    finish_run();
  end
endmodule